// File: doc/BRIEF.md
# Iterative Decimal (BCD) Multiplier

This block forms the product of two unsigned decimal numbers of `N` digits each, both coded as packed BCD, and returns the full `2N`-digit BCD product. In each cycle it takes one multiplier digit and multiplies the whole multiplicand by it. This work is done by a row of `N` single-digit decimal multipliers that run side by side. Each single-digit multiplier gives a tens digit and a units digit. The row places the tens digits one position above the units digits and adds the two with a decimal adder, which produces an `N+1`-digit partial product.

A second stage adds each partial product into a decimal accumulator. Multiplier digits are consumed least significant first. On every step the lowest digit of the sum moves out into the low half of the result, and the rest becomes the new running high half.

Control is a two-state machine, `ST_IDLE` and `ST_RUN`, which sequences partial-product generation. The transitions are:
- `ST_IDLE -> ST_RUN` when operands are accepted.
- `ST_RUN -> ST_RUN` while digits remain to be processed, and also on the last digit when a new pair of operands is accepted in that same cycle.
- `ST_RUN -> ST_IDLE` on the last digit when no new operands arrive.

Because accumulation is one stage behind generation, the last accumulation of one product runs in the same cycle as the first partial product of the next. The block therefore delivers a result `N+1` cycles after accepting the operands and can accept a new pair every `N` cycles.

Top module: `bcd_iter_mult`

## Requirements
- R1: `product` equals the decimal product of `mcand` and `mplier`. Digit k of every operand and of the product sits at bits [4k+3:4k], with digit 0 least significant.
- R2: `valid` is high in the cycle that follows the (N+1)-th rising edge after the accepting edge. The accepting edge is a rising edge at which `start` and `ready` are both high.
- R3: While an operation runs, `ready` is high again exactly N cycles after the accepting edge. A `start` held high at that point is accepted, so operations can issue back to back every N cycles.
- R4: `valid` is a one-cycle pulse for each completed operation, and `product` holds its value until the next pulse.
- R5: `ready` is high whenever the block is idle, and it is low during the N-1 cycles that follow an accepting edge.
- R6: `start` is ignored while `ready` is low. It causes no extra `valid` pulse, and the result of the running operation is unchanged.
- R7: A synchronous active-high `rst` clears `valid`, `product` and the accumulator, drops any operation in flight, and leaves `ready` high.
- R8: Corner cases give exact results: all-nines times all-nines gives 9…980…01, and a zero operand gives zero.
- R9: Every digit of `product` lies in the range 0 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to accept the operands |
| mcand | input | 4*N | Multiplicand, packed BCD |
| mplier | input | 4*N | Multiplier, packed BCD |
| ready | output | 1 | Operands are taken at this edge if `start` is high |
| product | output | 8*N | Product, packed BCD |
| valid | output | 1 | One-cycle strobe marking a new product |

## Verification
The bench builds two copies of the block: one with N=4 and one with N=8. The N=4 copy has a short issue interval, which makes it practical to check the `ready` drop window, the handling of ignored `start`, and reset during an operation one cycle at a time. The N=8 copy exercises 16-digit results, including the longest decimal carry chains in the all-nines case. Both copies run table vectors back to back at the full issue rate, so the overlap between the last accumulation and the next first partial product is covered on each, and results are compared against an integer product converted to BCD.

// File: rtl/bcd_mul_pkg.sv
package bcd_mul_pkg;

    typedef logic [3:0] dgt_t;

    typedef enum logic {ST_IDLE, ST_RUN} gen_state_t;

    // one decimal digit add: returns {carry, digit}
    function automatic logic [4:0] dgt_add(dgt_t a, dgt_t b, logic ci);
        logic [4:0] raw;
        logic [4:0] adj;
        raw = {1'b0, a} + {1'b0, b} + {4'b0000, ci};
        adj = raw + 5'd6;
        if (raw > 5'd9) begin
            return {1'b1, adj[3:0]};
        end
        return raw;
    endfunction

endpackage

// File: rtl/bcd_adder.sv
module bcd_adder #(
    parameter int DIGITS = 4
) (
    input  logic [4*DIGITS-1:0] a,
    input  logic [4*DIGITS-1:0] b,
    input  logic                cin,
    output logic [4*DIGITS-1:0] sum,
    output logic                cout
);
    import bcd_mul_pkg::*;

    always_comb begin
        logic       carry;
        logic [4:0] r;
        carry = cin;
        sum   = '0;
        for (int i = 0; i < DIGITS; i++) begin
            r             = dgt_add(a[4*i +: 4], b[4*i +: 4], carry);
            sum[4*i +: 4] = r[3:0];
            carry         = r[4];
        end
        cout = carry;
    end

endmodule

// File: rtl/bcd_digit_mul.sv
module bcd_digit_mul
    import bcd_mul_pkg::*;
(
    input  dgt_t x,
    input  dgt_t y,
    output dgt_t tens,
    output dgt_t units
);
    logic [6:0] p;

    assign p = {3'b000, x} * {3'b000, y};

    always_comb begin
        tens = '0;
        for (int k = 1; k <= 8; k++) begin
            if (p >= 7'(10 * k)) begin
                tens = 4'(k);
            end
        end
        units = 4'(p - 7'(10 * tens));
    end

    // R9: a legal digit pair yields a legal two-digit result
    always_comb begin
        if (x <= 4'd9 && y <= 4'd9) begin
            a_r9_digit_mul_range: assert (units <= 4'd9 && tens <= 4'd8);
        end
    end

endmodule

// File: rtl/bcd_pp_row.sv
module bcd_pp_row
    import bcd_mul_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [4*N-1:0]     mcand,
    input  dgt_t               mdig,
    output logic [4*(N+1)-1:0] pp
);
    logic [4*N-1:0] tens_v;
    logic [4*N-1:0] units_v;
    logic           row_cout;

    for (genvar g = 0; g < N; g++) begin : g_col
        bcd_digit_mul u_dm (
            .x    (mcand[4*g +: 4]),
            .y    (mdig),
            .tens (tens_v[4*g +: 4]),
            .units(units_v[4*g +: 4])
        );
    end

    // tens digits sit one position above the units digits
    bcd_adder #(.DIGITS(N+1)) u_add (
        .a   ({4'h0, units_v}),
        .b   ({tens_v, 4'h0}),
        .cin (1'b0),
        .sum (pp),
        .cout(row_cout)
    );

    // R1: a partial product never exceeds N+1 digits
    always_comb begin
        a_r1_row_fits: assert (row_cout == 1'b0);
    end

endmodule

// File: rtl/bcd_iter_mult.sv
module bcd_iter_mult
    import bcd_mul_pkg::*;
#(
    parameter int N = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [4*N-1:0] mcand,
    input  logic [4*N-1:0] mplier,
    output logic           ready,
    output logic [8*N-1:0] product,
    output logic           valid
);
    localparam int DW = 4 * N;
    localparam int PW = DW + 4;
    localparam int CW = $clog2(N);
    localparam logic [CW-1:0] LAST_IDX = CW'(N - 1);

    gen_state_t     state, state_nx;
    logic [CW-1:0]  cnt;
    logic [DW-1:0]  opa, opb;
    logic           accept, gen_last, gen_on;

    logic [PW-1:0]  pp_nx, pp_q;
    logic           pp_vld, pp_first, pp_last;

    logic [DW-1:0]  acc_hi, acc_lo;
    logic [PW-1:0]  acc_base, acc_sum;
    logic           acc_cout;

    // ---------------- control ----------------
    always_comb begin
        gen_on   = (state == ST_RUN);
        gen_last = gen_on && (cnt == LAST_IDX);
        ready    = (state == ST_IDLE) || gen_last;
        accept   = start && ready;
        unique case (state)
            ST_IDLE: state_nx = accept ? ST_RUN : ST_IDLE;
            ST_RUN:  state_nx = (gen_last && !accept) ? ST_IDLE : ST_RUN;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // ---------------- stage 1: partial products ----------------
    bcd_pp_row #(.N(N)) u_row (
        .mcand(opa),
        .mdig (opb[3:0]),
        .pp   (pp_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            opa      <= '0;
            opb      <= '0;
            pp_q     <= '0;
            pp_vld   <= 1'b0;
            pp_first <= 1'b0;
            pp_last  <= 1'b0;
        end else begin
            pp_vld   <= gen_on;
            pp_first <= gen_on && (cnt == '0);
            pp_last  <= gen_last;
            if (gen_on) begin
                pp_q <= pp_nx;
                opb  <= {4'h0, opb[DW-1:4]};
                cnt  <= cnt + 1'b1;
            end
            if (accept) begin
                opa <= mcand;
                opb <= mplier;
                cnt <= '0;
            end
        end
    end

    // ---------------- stage 2: decimal accumulation ----------------
    assign acc_base = pp_first ? '0 : {4'h0, acc_hi};

    bcd_adder #(.DIGITS(N+1)) u_acc (
        .a   (acc_base),
        .b   (pp_q),
        .cin (1'b0),
        .sum (acc_sum),
        .cout(acc_cout)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_hi  <= '0;
            acc_lo  <= '0;
            product <= '0;
            valid   <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (pp_vld) begin
                acc_hi <= acc_sum[PW-1:4];
                acc_lo <= {acc_sum[3:0], acc_lo[DW-1:4]};
                if (pp_last) begin
                    product <= {acc_sum, acc_lo[DW-1:4]};
                    valid   <= 1'b1;
                end
            end
        end
    end

    // ---------------- assertions ----------------
    logic digit_bad;
    always_comb begin
        digit_bad = 1'b0;
        for (int i = 0; i < 2*N; i++) begin
            if (product[4*i +: 4] > 4'd9) digit_bad = 1'b1;
        end
    end

    a_r1_acc_no_carry: assert property (@(posedge clk) disable iff (rst)
        pp_vld |-> !acc_cout);

    a_r2_last_step_valid: assert property (@(posedge clk) disable iff (rst)
        (pp_vld && pp_last) |=> valid);

    a_r4_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    a_r5_ready_drops: assert property (@(posedge clk) disable iff (rst)
        (start && ready) |=> !ready);

    a_r7_reset_clears: assert property (@(posedge clk)
        rst |=> (!valid && ready));

    a_r9_product_digits: assert property (@(posedge clk) disable iff (rst)
        valid |-> !digit_bad);

endmodule

// File: tb/sim_bcd_iter_mult.sv
`timescale 1ns/1ps
module sim_bcd_iter_mult;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;   // 125 MHz

    logic        start4 = 1'b0, start8 = 1'b0;
    logic [15:0] a4 = '0, b4 = '0;
    logic [31:0] a8 = '0, b8 = '0;
    logic        rdy4, rdy8, v4, v8;
    logic [31:0] p4;
    logic [63:0] p8;

    bcd_iter_mult #(.N(4)) u0 (
        .clk(clk), .rst(rst), .start(start4), .mcand(a4), .mplier(b4),
        .ready(rdy4), .product(p4), .valid(v4));

    bcd_iter_mult #(.N(8)) u1 (
        .clk(clk), .rst(rst), .start(start8), .mcand(a8), .mplier(b8),
        .ready(rdy8), .product(p8), .valid(v8));

    int checks = 0, fails = 0, cyc = 0;
    bit finished = 0;
    always @(posedge clk) cyc <= cyc + 1;

    longint unsigned q4e[$], q8e[$];
    int              q4c[$], q8c[$];
    logic [31:0] last4 = '0;
    logic [63:0] last8 = '0;
    bit vprev4 = 0, vprev8 = 0, hold4 = 0, hold8 = 0;
    int nval4 = 0, nval8 = 0;

    // operand A, operand B, expected decimal product
    localparam longint unsigned T4 [8][3] = '{
        '{1234, 5678, 7006652}, '{9999, 9999, 99980001}, '{0, 4321, 0},
        '{1, 9999, 9999}, '{5000, 2, 10000}, '{4567, 8910, 40691970},
        '{1111, 1111, 1234321}, '{2500, 4000, 10000000}};
    localparam longint unsigned T8 [6][2] = '{
        '{12345678, 87654321}, '{99999999, 99999999}, '{10000000, 10000000},
        '{0, 55555555}, '{98765432, 3}, '{50505050, 20202020}};

    function automatic logic [63:0] to_bcd(longint unsigned v);
        logic [63:0] r;
        longint unsigned t;
        t = v;
        r = '0;
        for (int i = 0; i < 16; i++) begin
            r[4*i +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    function automatic bit digits_ok(logic [63:0] v);
        for (int i = 0; i < 16; i++) if (v[4*i +: 4] > 4'd9) return 0;
        return 1;
    endfunction

    task automatic chk(bit ok, string req, longint unsigned act, longint unsigned exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // ---------------- monitors ----------------
    always @(negedge clk) begin
        if (rst) begin
            q4e.delete(); q4c.delete(); vprev4 = 0; hold4 = 0;
        end else begin
            if (v4) begin
                longint unsigned e; int c;
                nval4++;
                chk(!vprev4, "R4 single pulse", 1, 0);
                chk(digits_ok({32'h0, p4}), "R9", p4, 0);
                if (q4e.size() == 0) chk(0, "R6 unexpected valid", p4, 0);
                else begin
                    e = q4e.pop_front(); c = q4c.pop_front();
                    chk(p4 == e[31:0], "R1 N=4", p4, e);
                    chk(cyc - c == 5, "R2 N=4", cyc - c, 5);
                end
                last4 = p4; hold4 = 1;
            end else if (hold4) begin
                chk(p4 == last4, "R4 hold", p4, last4);
                hold4 = 0;
            end
            vprev4 = v4;
        end
    end

    always @(negedge clk) begin
        if (rst) begin
            q8e.delete(); q8c.delete(); vprev8 = 0; hold8 = 0;
        end else begin
            if (v8) begin
                longint unsigned e; int c;
                nval8++;
                chk(!vprev8, "R4 single pulse", 1, 0);
                chk(digits_ok(p8), "R9", p8, 0);
                if (q8e.size() == 0) chk(0, "R6 unexpected valid", p8, 0);
                else begin
                    e = q8e.pop_front(); c = q8c.pop_front();
                    chk(p8 == e, "R1 N=8", p8, e);
                    chk(cyc - c == 9, "R2 N=8", cyc - c, 9);
                end
                last8 = p8; hold8 = 1;
            end else if (hold8) begin
                chk(p8 == last8, "R4 hold", p8, last8);
                hold8 = 0;
            end
            vprev8 = v8;
        end
    end

    // ---------------- drivers (called at a negedge) ----------------
    int prev_acc = -1;

    task automatic drive4(longint unsigned x, longint unsigned y, longint unsigned exp, bit gap);
        logic [63:0] tx, ty;
        tx = to_bcd(x); ty = to_bcd(y);
        start4 = 1'b1; a4 = tx[15:0]; b4 = ty[15:0];
        while (!rdy4) @(negedge clk);
        q4e.push_back(to_bcd(exp)); q4c.push_back(cyc + 1);
        if (!gap && prev_acc >= 0) chk(cyc + 1 - prev_acc == 4, "R3 N=4", cyc + 1 - prev_acc, 4);
        prev_acc = cyc + 1;
        @(negedge clk);
        if (gap) start4 = 1'b0;
    endtask

    task automatic drive8(longint unsigned x, longint unsigned y, bit gap);
        logic [63:0] tx, ty;
        tx = to_bcd(x); ty = to_bcd(y);
        start8 = 1'b1; a8 = tx[31:0]; b8 = ty[31:0];
        while (!rdy8) @(negedge clk);
        q8e.push_back(to_bcd(x * y)); q8c.push_back(cyc + 1);
        if (!gap && prev_acc >= 0) chk(cyc + 1 - prev_acc == 8, "R3 N=8", cyc + 1 - prev_acc, 8);
        prev_acc = cyc + 1;
        @(negedge clk);
        if (gap) start8 = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog R2 actual=timeout expected=completion");
        summary();
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        // R7: reset state
        chk(!v4 && !v8, "R7 valid", {v4, v8}, 0);
        chk(rdy4 && rdy8, "R7 ready", {rdy4, rdy8}, 3);
        chk(p4 == 0, "R7 product", p4, 0);
        chk(p8 == 0, "R7 product", p8, 0);
        rst = 1'b0;
        @(negedge clk);

        // table, back to back, N=4 (R1 R2 R3 R8)
        prev_acc = -1;
        for (int i = 0; i < 8; i++) drive4(T4[i][0], T4[i][1], T4[i][2], 0);
        start4 = 1'b0;
        repeat (8) @(negedge clk);
        chk(q4e.size() == 0, "R2 all N=4 done", q4e.size(), 0);

        // table, back to back, N=8
        prev_acc = -1;
        for (int i = 0; i < 6; i++) drive8(T8[i][0], T8[i][1], 0);
        start8 = 1'b0;
        repeat (12) @(negedge clk);
        chk(q8e.size() == 0, "R2 all N=8 done", q8e.size(), 0);

        // isolated operations with idle gaps, R5 ready while idle
        drive4(8765, 9, 78885, 1);
        repeat (7) @(negedge clk);
        chk(rdy4, "R5 idle ready", rdy4, 1);
        // R8 corners
        drive4(9999, 9999, 99980001, 1);
        repeat (7) @(negedge clk);
        chk(last4 == 32'h99980001, "R8 nines N=4", last4, 32'h99980001);
        drive4(0, 9999, 0, 1);
        repeat (7) @(negedge clk);
        chk(last4 == 32'h0, "R8 zero N=4", last4, 0);
        drive8(99999999, 99999999, 1);
        repeat (11) @(negedge clk);
        chk(last8 == 64'h9999999800000001, "R8 nines N=8", last8, 64'h9999999800000001);

        // R5 / R6: start held while ready low is ignored
        base = nval4;
        start4 = 1'b1; a4 = 16'h1234; b4 = 16'h0002;
        chk(rdy4, "R5 idle ready", rdy4, 1);
        q4e.push_back(64'h2468); q4c.push_back(cyc + 1);
        @(negedge clk);
        a4 = 16'h9999; b4 = 16'h9999;
        for (int j = 1; j <= 3; j++) begin
            chk(!rdy4, "R5 busy", rdy4, 0);
            @(negedge clk);
        end
        chk(rdy4, "R3 ready after N", rdy4, 1);
        start4 = 1'b0;
        repeat (4) @(negedge clk);
        chk(nval4 == base + 1, "R6 one result", nval4 - base, 1);
        chk(last4 == 32'h2468, "R6 result kept", last4, 32'h2468);

        // R7: reset in the middle of an operation
        start4 = 1'b1; a4 = 16'h4321; b4 = 16'h4321;
        @(negedge clk);
        start4 = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        base = nval4;
        for (int j = 0; j < 8; j++) @(negedge clk);
        chk(nval4 == base, "R7 op dropped", nval4 - base, 0);
        chk(rdy4, "R7 ready", rdy4, 1);
        chk(p4 == 0, "R7 product cleared", p4, 0);

        summary();
    end

endmodule